// File: doc/BRIEF.md
# Integer Conditional Branch Resolver with Delay-Slot Annul

This block resolves integer conditional branches for an in-order pipeline that has one architectural delay slot. The decode stage presents a branch: a 4-bit condition selector, an annul flag, a signed 22-bit word displacement, the branch's own PC and the current N/Z/V/C integer condition codes. The block registers that bundle. One cycle later it reports whether the branch is taken, its target address, the PC that fetch should use once the delay slot has been issued, and whether the delay-slot instruction must be squashed.

The condition field has sixteen codes: always, never, signed and unsigned magnitude comparisons, and tests on the sign, carry and overflow flags. Bit 3 of the selector inverts the test chosen by bits 2:0. With the annul flag clear, the delay slot always executes. With the flag set, the delay slot survives only when the branch is taken. The one exception is the unconditional branch: with annul set it is taken and its delay slot is still squashed.

Top module: `brc_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `br_resolved`, `br_taken` and `slot_squash` are 0.
- R2: A branch presented with `in_valid` high at a rising edge is reported in the following cycle with `br_resolved` high. In a cycle that follows an edge with `in_valid` low, `br_resolved`, `br_taken` and `slot_squash` are all 0.
- R3: With selector bit 3 clear, the taken test for bits 2:0 is: 000 never, 001 Z, 010 Z or (N xor V), 011 N xor V, 100 C or Z, 101 C, 110 N, 111 V. The condition codes are `in_icc` = {N,Z,V,C} with N at bit 3.
- R4: With selector bit 3 set, the taken result is the complement of the R3 result for the same bits 2:0. This gives 1000 always, 1001 not-equal, 1010 greater, 1011 greater-or-equal, 1100 greater-unsigned, 1101 carry clear, 1110 positive and 1111 overflow clear.
- R5: `br_target` equals the branch PC plus the sign-extended displacement shifted left by two. The sum wraps modulo 2^PC_W.
- R6: With the annul flag clear, `slot_squash` is 0 for that branch.
- R7: With the annul flag set and the branch not taken (this includes the never code), `slot_squash` is 1.
- R8: With the annul flag set and a taken conditional branch (any code other than 1000), `slot_squash` is 0.
- R9: The always code 1000 with the annul flag set gives `br_taken` = 1 and `slot_squash` = 1.
- R10: When resolved, `next_pc` equals `br_target` if the branch is taken, and otherwise the branch PC plus 8, the address after the delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A branch is presented this cycle |
| in_cond | input | 4 | Condition selector |
| in_annul | input | 1 | Annul flag for the delay slot |
| in_disp | input | DISP_W | Signed word displacement |
| in_pc | input | PC_W | Address of the branch |
| in_icc | input | 4 | Condition codes {N,Z,V,C} |
| br_resolved | output | 1 | A captured branch is being reported |
| br_taken | output | 1 | Branch condition holds |
| slot_squash | output | 1 | Squash the delay-slot instruction |
| br_target | output | PC_W | Branch target address |
| next_pc | output | PC_W | Fetch address after the delay slot |

## Verification
The output stage holds no state beyond the captured bundle. A corrupted capture register therefore shows at the ports in the very next cycle, as a wrong taken bit, target or squash for that branch. The bench sweeps every condition code against all sixteen flag combinations with annul both clear and set, and compares every output cycle against a behavioural model. A mis-decoded selector or flag therefore shows up within one cycle of the first branch that uses it. Extreme displacements and a PC near the top of the address space show up any sign-extension or carry error in the target on the cycle it occurs.

// File: rtl/brc_pkg.sv
// Shared types and constants for the branch resolver.
// Assumes the condition codes arrive packed as {N,Z,V,C}.
package brc_pkg;
    localparam int COND_W = 4;
    localparam int ICC_W  = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } brc_icc_t;

    // Base tests selected by selector bits 2:0 (bit 3 inverts).
    typedef enum logic [2:0] {
        BASE_NEVER = 3'b000,
        BASE_EQ    = 3'b001,
        BASE_LE    = 3'b010,
        BASE_LT    = 3'b011,
        BASE_LEU   = 3'b100,
        BASE_CS    = 3'b101,
        BASE_NEG   = 3'b110,
        BASE_VS    = 3'b111
    } brc_base_e;

    localparam logic [COND_W-1:0] COND_ALWAYS = 4'b1000;
endpackage

// File: rtl/brc_capture.sv
// Input stage register for one branch bundle.
// Assumes the decode stage holds nothing: each bundle is sampled once.
module brc_capture
    import brc_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DISP_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [COND_W-1:0] d_cond,
    input  logic              d_annul,
    input  logic [DISP_W-1:0] d_disp,
    input  logic [PC_W-1:0]   d_pc,
    input  logic [ICC_W-1:0]  d_icc,
    output logic              q_valid,
    output logic [COND_W-1:0] q_cond,
    output logic              q_annul,
    output logic [DISP_W-1:0] q_disp,
    output logic [PC_W-1:0]   q_pc,
    output brc_icc_t          q_icc
);
    // Capture the bundle on every edge; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_cond  <= '0;
            q_annul <= 1'b0;
            q_disp  <= '0;
            q_pc    <= '0;
            q_icc   <= '0;
        end else begin
            q_valid <= d_valid;
            q_cond  <= d_cond;
            q_annul <= d_annul;
            q_disp  <= d_disp;
            q_pc    <= d_pc;
            q_icc   <= brc_icc_t'(d_icc);
        end
    end
endmodule

// File: rtl/brc_cond_eval.sv
// Evaluates a 4-bit branch condition against the integer condition codes.
// Bits 2:0 pick a base test and bit 3 inverts it. Purely combinational.
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  brc_icc_t          icc,
    output logic              holds
);
    logic base_hit;
    logic signed_lt;

    // Select the base test from the low selector bits.
    always_comb begin
        signed_lt = icc.n ^ icc.v;
        unique case (brc_base_e'(cond[2:0]))
            BASE_NEVER: base_hit = 1'b0;
            BASE_EQ:    base_hit = icc.z;
            BASE_LE:    base_hit = icc.z | signed_lt;
            BASE_LT:    base_hit = signed_lt;
            BASE_LEU:   base_hit = icc.c | icc.z;
            BASE_CS:    base_hit = icc.c;
            BASE_NEG:   base_hit = icc.n;
            BASE_VS:    base_hit = icc.v;
            default:    base_hit = 1'b0;
        endcase
    end

    // Apply the inversion bit.
    always_comb holds = base_hit ^ cond[3];
endmodule

// File: rtl/brc_target_gen.sv
// Computes the branch target and the fall-through PC past the delay slot.
// Assumes PC_W >= DISP_W + 2; sums wrap modulo 2^PC_W.
module brc_target_gen #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 22
) (
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   target,
    output logic [PC_W-1:0]   fall_pc
);
    localparam int WORD_SH  = 2;
    localparam int EXT_W    = PC_W - DISP_W - WORD_SH;
    localparam logic [PC_W-1:0] SLOT_SKIP = PC_W'(8);

    logic [PC_W-1:0] offset;

    // Sign-extend the word displacement and scale it to bytes.
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb offset = {{EXT_W{disp[DISP_W-1]}}, disp, {WORD_SH{1'b0}}};
        end else begin : g_noext
            always_comb offset = {disp, {WORD_SH{1'b0}}};
        end
    endgenerate

    // Form both candidate next addresses.
    always_comb begin
        target  = pc + offset;
        fall_pc = pc + SLOT_SKIP;
    end
endmodule

// File: rtl/brc_unit.sv
// Branch resolver top: registers a branch bundle, then reports the taken
// decision, target, post-slot fetch PC and delay-slot squash one cycle later.
// Assumes one branch per cycle at most and a single delay slot.
module brc_unit
    import brc_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DISP_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_cond,
    input  logic              in_annul,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [3:0]        in_icc,
    output logic              br_resolved,
    output logic              br_taken,
    output logic              slot_squash,
    output logic [PC_W-1:0]   br_target,
    output logic [PC_W-1:0]   next_pc
);
    logic              cap_valid;
    logic [COND_W-1:0] cap_cond;
    logic              cap_annul;
    logic [DISP_W-1:0] cap_disp;
    logic [PC_W-1:0]   cap_pc;
    brc_icc_t          cap_icc;
    logic              cond_holds;
    logic [PC_W-1:0]   tgt;
    logic [PC_W-1:0]   fall;
    logic              is_always;

    brc_capture #(.PC_W(PC_W), .DISP_W(DISP_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .d_valid(in_valid), .d_cond(in_cond), .d_annul(in_annul),
        .d_disp(in_disp), .d_pc(in_pc), .d_icc(in_icc),
        .q_valid(cap_valid), .q_cond(cap_cond), .q_annul(cap_annul),
        .q_disp(cap_disp), .q_pc(cap_pc), .q_icc(cap_icc)
    );

    brc_cond_eval u_cond (
        .cond(cap_cond), .icc(cap_icc), .holds(cond_holds)
    );

    brc_target_gen #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .disp(cap_disp), .pc(cap_pc), .target(tgt), .fall_pc(fall)
    );

    // Decide taken/squash; the unconditional branch with annul squashes its slot.
    always_comb begin
        is_always   = (cap_cond == COND_ALWAYS);
        br_resolved = cap_valid;
        br_taken    = cap_valid & cond_holds;
        slot_squash = cap_valid & cap_annul & (~cond_holds | is_always);
        br_target   = tgt;
        next_pc     = cond_holds ? tgt : fall;
    end
endmodule

// File: rtl/brc_unit_checker.sv
// Temporal checks on the branch resolver's ports, bound into every instance.
module brc_unit_checker #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_cond,
    input logic              in_annul,
    input logic              br_resolved,
    input logic              br_taken,
    input logic              slot_squash,
    input logic [PC_W-1:0]   br_target,
    input logic [PC_W-1:0]   next_pc
);
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> br_resolved);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !br_resolved |-> (!br_taken && !slot_squash));
    a_r3_never_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond == 4'b0000) |=> !br_taken);
    a_r4_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond == 4'b1000) |=> br_taken);
    a_r6_keep_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_annul) |=> !slot_squash);
    a_r7_squash_untaken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_annul && in_cond != 4'b1000) |=> (slot_squash != br_taken));
    a_r9_always_annul: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_annul && in_cond == 4'b1000) |=> (br_taken && slot_squash));
    a_r10_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolved && br_taken) |-> (next_pc == br_target));
endmodule

bind brc_unit brc_unit_checker #(.PC_W(PC_W), .DISP_W(DISP_W)) u_brc_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cond(in_cond),
    .in_annul(in_annul), .br_resolved(br_resolved), .br_taken(br_taken),
    .slot_squash(slot_squash), .br_target(br_target), .next_pc(next_pc)
);

// File: tb/test_brc_unit.sv
// Bench: a behavioural model predicts each cycle's outputs from the bundle
// driven before the previous edge; outputs are compared on every falling edge.
module test_brc_unit;
    localparam int PC_W   = 32;
    localparam int DISP_W = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [3:0]        in_cond = '0;
    logic              in_annul = 1'b0;
    logic [DISP_W-1:0] in_disp = '0;
    logic [PC_W-1:0]   in_pc = '0;
    logic [3:0]        in_icc = '0;
    logic              br_resolved, br_taken, slot_squash;
    logic [PC_W-1:0]   br_target, next_pc;

    int n_checks = 0;
    int n_fails  = 0;

    always #2ns clk = ~clk;

    brc_unit #(.PC_W(PC_W), .DISP_W(DISP_W)) i_brc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cond(in_cond),
        .in_annul(in_annul), .in_disp(in_disp), .in_pc(in_pc), .in_icc(in_icc),
        .br_resolved(br_resolved), .br_taken(br_taken), .slot_squash(slot_squash),
        .br_target(br_target), .next_pc(next_pc)
    );

    function automatic bit model_taken(input logic [3:0] c, input logic [3:0] f);
        bit n, z, v, cy;
        n = f[3]; z = f[2]; v = f[1]; cy = f[0];
        case (c)
            4'h0: return 0;
            4'h8: return 1;
            4'h1: return z;
            4'h9: return !z;
            4'h2: return z || (n != v);
            4'hA: return !z && (n == v);
            4'h3: return n != v;
            4'hB: return n == v;
            4'h4: return cy || z;
            4'hC: return !cy && !z;
            4'h5: return cy;
            4'hD: return !cy;
            4'h6: return n;
            4'hE: return !n;
            4'h7: return v;
            default: return !v;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected bundle: what the design captured at the last rising edge.
    bit              e_valid;
    logic [3:0]      e_cond, e_icc;
    bit              e_annul;
    logic [DISP_W-1:0] e_disp;
    logic [PC_W-1:0] e_pc;

    task automatic compare_now();
        bit t, sq;
        longint tgt;
        string sqtag;
        if (!e_valid) begin
            check("R2", "resolved idle", br_resolved, 0);
            check("R2", "taken idle", br_taken, 0);
            check("R2", "squash idle", slot_squash, 0);
            return;
        end
        t   = model_taken(e_cond, e_icc);
        tgt = (longint'(e_pc) + (longint'($signed(e_disp)) * 4)) & 64'hFFFF_FFFF;
        if (!e_annul)            begin sq = 0; sqtag = "R6"; end
        else if (e_cond == 4'h8) begin sq = 1; sqtag = "R9"; end
        else if (t)              begin sq = 0; sqtag = "R8"; end
        else                     begin sq = 1; sqtag = "R7"; end
        check("R2", "resolved", br_resolved, 1);
        check(e_cond[3] ? "R4" : "R3", "taken", br_taken, t);
        check(sqtag, "squash", slot_squash, sq);
        check("R5", "target", br_target, tgt);
        check("R10", "next pc", next_pc,
              t ? tgt : ((longint'(e_pc) + 8) & 64'hFFFF_FFFF));
    endtask

    // Drive one bundle at a falling edge, after checking the previous one.
    task automatic step(input bit v, input logic [3:0] c, input bit a,
                        input logic [DISP_W-1:0] d, input logic [PC_W-1:0] p,
                        input logic [3:0] f);
        @(negedge clk);
        compare_now();
        in_valid = v; in_cond = c; in_annul = a; in_disp = d; in_pc = p; in_icc = f;
        e_valid = v; e_cond = c; e_annul = a; e_disp = d; e_pc = p; e_icc = f;
    endtask

    initial begin
        e_valid = 0;
        repeat (3) @(negedge clk);
        check("R1", "resolved in reset", br_resolved, 0);
        check("R1", "taken in reset", br_taken, 0);
        check("R1", "squash in reset", slot_squash, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "resolved after reset", br_resolved, 0);
        check("R1", "squash after reset", slot_squash, 0);
        // Full sweep: every code, every flag set, annul clear and set.
        for (int a = 0; a < 2; a++)
            for (int c = 0; c < 16; c++)
                for (int f = 0; f < 16; f++)
                    step(1, 4'(c), a[0], DISP_W'(c * 977 - f * 31),
                         32'h0040_0000 + 32'(f * 4), 4'(f));
        // Idle gap and boundary displacements.
        step(0, 4'h8, 1, '0, '0, '0);
        step(0, 4'h0, 0, '0, '0, '0);
        step(1, 4'h8, 0, 22'h1F_FFFF, 32'h0080_0000, 4'h0); // max forward
        step(1, 4'h8, 0, 22'h20_0000, 32'h0080_0000, 4'h0); // max backward
        step(1, 4'h8, 1, 22'h3F_FFFF, 32'h0000_0010, 4'h0); // -1 word
        step(1, 4'h8, 0, 22'h00_0010, 32'hFFFF_FFF8, 4'h0); // wrap past top
        step(1, 4'h1, 0, 22'h00_0004, 32'hFFFF_FFFC, 4'h0); // fall-through wraps
        // Pseudo-random mix with idle cycles.
        for (int i = 0; i < 2000; i++)
            step(($urandom % 4) != 0, 4'($urandom), 1'($urandom),
                 DISP_W'($urandom), 32'($urandom) & 32'hFFFF_FFFC, 4'($urandom));
        step(0, '0, 0, '0, '0, '0);
        step(0, '0, 0, '0, '0, '0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1ms;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule